// File: doc/BRIEF.md
# Banked Memory Sleep-State Sequencer

This block sits in front of a memory built from eight equal banks and owns each bank's three low-power controls: a retaining sleep, a non-retaining deep sleep and a full shutdown. A single request port carries an address, a write flag and write data. The upper three address bits pick the bank. The block grants the request only when that bank is awake and allowed by the current bandwidth setting. A behavioural bank model sits under every controller instance. Each model honours the sleep controls, so content loss can be observed at the read port.

A bandwidth input chooses between full operation and half operation. In full mode all eight banks serve requests. In half mode only banks 0 to 3 serve requests. Each of banks 4 to 7 is parked in a state chosen from its history: the retaining sleep if it holds written data, deep sleep if it was used since startup but holds nothing, and shutdown if it was never used since startup. When startup finishes, every bank that is not being used is shut down. A programmable idle count puts a quiet active bank into the retaining sleep. Any sleeping bank is woken by a request and has a guarded wake window before its first grant.

Top module: `bank_pwr_ctrl`

## Requirements
- R1: The bank index is address bits [6:4] and the word index is bits [3:0]. A granted write stores the data. A granted read raises `rvalid_o` in the next cycle, with the stored word on `rdata_o`.
- R2: In full mode every bank can be granted. In half mode a request to bank 4 to 7 is refused: `blk_o`=1 and `gnt_o`=0 while it is held, and the bank's sleep control stays unchanged.
- R3: On entering half mode, a bank among 4 to 7 that holds written data goes to the retaining sleep. Its contents read back intact after a later wake. Banks 0 to 3 stay ready and keep their data.
- R4: On entering half mode, a bank among 4 to 7 without written data goes to deep sleep if it was accessed since startup, and to shutdown otherwise. A read after deep sleep or shutdown returns all ones for words not rewritten.
- R5: Two cycles after `boot_done_i` is first sampled high, every bank not being accessed is in shutdown and has lost its data.
- R6: With `idle_lim_i`=N>0, an active bank that sees no request for N consecutive cycles enters the retaining sleep in the following cycle. If a request arrives in the N-th quiet cycle, it is granted at once instead. N=0 disables this.
- R7: A request to a bank in retaining sleep is granted 3 cycles after the request first appears (2 wake cycles). From deep sleep or shutdown the grant comes after 5 cycles (4 wake cycles). During the wake window the bank shows no sleep control and is not ready.
- R8: `void_o` is high in any cycle where a request targets a bank in deep sleep or shutdown, and low for a bank in retaining sleep.
- R9: Per bank, at most one of the three sleep controls is high, and `rdy_o` is high only when none is.
- R10: `gnt_o` is never high unless the addressed bank is ready.
- R11: After reset all banks are ready, all sleep controls are low and no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_i | input | 1 | 1 selects half bandwidth (banks 0 to 3 only) |
| boot_done_i | input | 1 | Startup finished (sticky once seen) |
| idle_lim_i | input | 6 | Quiet cycles before idle sleep, 0 disables |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 7 | Bank index [6:4], word index [3:0] |
| wdata_i | input | 8 | Write data |
| gnt_o | output | 1 | Request accepted this cycle |
| blk_o | output | 1 | Request refused by half mode |
| void_o | output | 1 | Request targets a non-retaining bank |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 8 | Read data |
| ls_o | output | 8 | Per-bank retaining sleep control |
| ds_o | output | 8 | Per-bank deep sleep control |
| sd_o | output | 8 | Per-bank shutdown control |
| rdy_o | output | 8 | Per-bank ready |

## Verification
The idle timer and a new request can decide the same bank's next state in the same cycle. To provoke this, the bench waits until the exact cycle in which the idle count would expire and issues a request in that cycle. The result is judged by an immediate grant with no wake delay and the retaining-sleep control staying low. A second collision is a mode change arriving while requests target upper banks. This is judged by the refusal flag together with the parked control remaining unchanged.

// File: rtl/bank_pwr_pkg.sv
package bank_pwr_pkg;
  typedef enum logic [2:0] {
    BK_ON   = 3'd0,
    BK_LS   = 3'd1,
    BK_DS   = 3'd2,
    BK_SD   = 3'd3,
    BK_WAKE = 3'd4
  } bank_st_e;
endpackage

// File: rtl/bank_fsm.sv
module bank_fsm
  import bank_pwr_pkg::*;
#(
  parameter int IDLE_W    = 6,
  parameter int WAKE_LS   = 2,
  parameter int WAKE_DEEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want_i,
  input  logic              boot_i,
  input  logic              hit_i,
  input  logic              wr_i,
  input  logic [IDLE_W-1:0] idle_lim_i,
  output logic              ls_o,
  output logic              ds_o,
  output logic              sd_o,
  output logic              rdy_o
);
  localparam int WCNT_W = $clog2(WAKE_DEEP + 1);
  localparam logic [WCNT_W-1:0] LS_LOAD   = WCNT_W'(WAKE_LS - 1);
  localparam logic [WCNT_W-1:0] DEEP_LOAD = WCNT_W'(WAKE_DEEP - 1);

  bank_st_e          st_q, st_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic [IDLE_W-1:0] icnt_q, icnt_d;
  logic              used_q, used_d;
  logic              full_q, full_d;

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    icnt_d = icnt_q;
    used_d = used_q;
    full_d = full_q;
    unique case (st_q)
      BK_ON: begin
        if (!want_i) begin
          icnt_d = '0;
          if (full_q)      st_d = BK_LS;
          else if (used_q) st_d = BK_DS;
          else             st_d = BK_SD;
        end else if (hit_i) begin
          icnt_d = '0;
          if (boot_i) used_d = 1'b1;
          if (wr_i)   full_d = 1'b1;
        end else if (boot_i && !used_q) begin
          st_d = BK_SD;
        end else if (idle_lim_i != '0) begin
          if (icnt_q >= idle_lim_i - 1'b1) begin
            st_d   = BK_LS;
            icnt_d = '0;
          end else begin
            icnt_d = icnt_q + 1'b1;
          end
        end
      end
      BK_LS, BK_DS, BK_SD: begin
        if (want_i && hit_i) begin
          st_d   = BK_WAKE;
          wcnt_d = (st_q == BK_LS) ? LS_LOAD : DEEP_LOAD;
          icnt_d = '0;
        end
      end
      BK_WAKE: begin
        if (wcnt_q == '0) st_d = BK_ON;
        else              wcnt_d = wcnt_q - 1'b1;
      end
      default: st_d = BK_ON;
    endcase
    if (st_d == BK_DS || st_d == BK_SD) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BK_ON;
      wcnt_q <= '0;
      icnt_q <= '0;
      used_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      icnt_q <= icnt_d;
      used_q <= used_d;
      full_q <= full_d;
    end
  end

  assign ls_o  = (st_q == BK_LS);
  assign ds_o  = (st_q == BK_DS);
  assign sd_o  = (st_q == BK_SD);
  assign rdy_o = (st_q == BK_ON);
endmodule

// File: rtl/bank_ram.sv
module bank_ram #(
  parameter int DATA_W = 8,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ls_i,
  input  logic              ds_i,
  input  logic              sd_i,
  input  logic              ce_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORDS = 1 << WORD_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  held_q;
  logic              acc;

  assign acc = ce_i && !(ls_i || ds_i || sd_i);

  always_ff @(posedge clk) begin
    if (acc && we_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              held_q <= '0;
    else if (ds_i || sd_i)   held_q <= '0;
    else if (acc && we_i)    held_q[addr_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (acc && !we_i) rdata_o <= held_q[addr_i] ? mem[addr_i] : '1;
  end
endmodule

// File: rtl/bank_pwr_ctrl.sv
module bank_pwr_ctrl #(
  parameter int NBANK     = 8,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int IDLE_W    = 6,
  parameter int WAKE_LS   = 2,
  parameter int WAKE_DEEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_i,
  input  logic              boot_done_i,
  input  logic [IDLE_W-1:0] idle_lim_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              gnt_o,
  output logic              blk_o,
  output logic              void_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NBANK-1:0]  ls_o,
  output logic [NBANK-1:0]  ds_o,
  output logic [NBANK-1:0]  sd_o,
  output logic [NBANK-1:0]  rdy_o
);
  localparam int BSEL_W   = $clog2(NBANK);
  localparam int WORD_W   = ADDR_W - BSEL_W;
  localparam int HALF_SET = NBANK / 2;

  logic [1:0]        rs_q;
  logic              rst_int_n;
  logic              boot_q;
  logic [BSEL_W-1:0] idx, sel_q;
  logic [NBANK-1:0]  want, hit;
  logic              rvalid_q;
  logic [DATA_W-1:0] brd [NBANK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)       boot_q <= 1'b0;
    else if (boot_done_i) boot_q <= 1'b1;
  end

  assign idx    = addr_i[ADDR_W-1 -: BSEL_W];
  assign gnt_o  = req_i && want[idx] && rdy_o[idx];
  assign blk_o  = req_i && !want[idx];
  assign void_o = req_i && (ds_o[idx] || sd_o[idx]);

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign want[b] = !half_i || (b < HALF_SET);
      assign hit[b]  = req_i && (idx == BSEL_W'(b));

      bank_fsm #(
        .IDLE_W   (IDLE_W),
        .WAKE_LS  (WAKE_LS),
        .WAKE_DEEP(WAKE_DEEP)
      ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .want_i    (want[b]),
        .boot_i    (boot_q),
        .hit_i     (hit[b]),
        .wr_i      (we_i),
        .idle_lim_i(idle_lim_i),
        .ls_o      (ls_o[b]),
        .ds_o      (ds_o[b]),
        .sd_o      (sd_o[b]),
        .rdy_o     (rdy_o[b])
      );

      bank_ram #(
        .DATA_W(DATA_W),
        .WORD_W(WORD_W)
      ) u_ram (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .ls_i   (ls_o[b]),
        .ds_i   (ds_o[b]),
        .sd_i   (sd_o[b]),
        .ce_i   (gnt_o && hit[b]),
        .we_i   (we_i),
        .addr_i (addr_i[WORD_W-1:0]),
        .wdata_i(wdata_i),
        .rdata_o(brd[b])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rvalid_q <= 1'b0;
      sel_q    <= '0;
    end else begin
      rvalid_q <= gnt_o && !we_i;
      if (gnt_o) sel_q <= idx;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = brd[sel_q];
endmodule

// File: rtl/bank_pwr_chk.sv
module bank_pwr_chk #(
  parameter int NBANK  = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              gnt_o,
  input logic              blk_o,
  input logic              void_o,
  input logic              rvalid_o,
  input logic [NBANK-1:0]  ls_o,
  input logic [NBANK-1:0]  ds_o,
  input logic [NBANK-1:0]  sd_o,
  input logic [NBANK-1:0]  rdy_o
);
  localparam int BSEL_W = $clog2(NBANK);

  // R10
  gnt_needs_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_o |-> (req_i && rdy_o[addr_i[ADDR_W-1 -: BSEL_W]]));

  // R2
  blk_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_o |-> !gnt_o);

  // R8
  void_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    void_o |-> !gnt_o);

  // R1
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o && !we_i) |=> rvalid_o);

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_chk
      // R9
      pin_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ls_o[b], ds_o[b], sd_o[b]}));
      // R9
      rdy_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o[b] |-> !(ls_o[b] || ds_o[b] || sd_o[b]));
      // R7
      wake_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_o[b] || ds_o[b] || sd_o[b]) |=> !rdy_o[b]);
    end
  endgenerate
endmodule

bind bank_pwr_ctrl bank_pwr_chk #(
  .NBANK (NBANK),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .gnt_o   (gnt_o),
  .blk_o   (blk_o),
  .void_o  (void_o),
  .rvalid_o(rvalid_o),
  .ls_o    (ls_o),
  .ds_o    (ds_o),
  .sd_o    (sd_o),
  .rdy_o   (rdy_o)
);

// File: tb/sim_bank_pwr_ctrl.sv
module sim_bank_pwr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, half, boot, req, we;
  logic [5:0] lim;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;
  logic       gnt, blk, vd, rvalid;
  logic [7:0] ls, ds, sd, rdy;
  int total = 0, bad = 0;
  bit fin = 1'b0;

  always #2 clk = ~clk;

  bank_pwr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .half_i(half), .boot_done_i(boot), .idle_lim_i(lim),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .gnt_o(gnt), .blk_o(blk), .void_o(vd), .rvalid_o(rvalid), .rdata_o(rdata),
    .ls_o(ls), .ds_o(ds), .sd_o(sd), .rdy_o(rdy)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int b, input int w);
    return 8'((b * 16 + w) ^ 8'hA5);
  endfunction

  // one access; returns cycles waited before grant, read data, void at first cycle,
  // and whether the wake window showed no sleep control and no ready
  task automatic access(input logic wr, input int b, input int w, input logic [7:0] d,
                        output int waited, output logic [7:0] rd,
                        output logic vfirst, output logic clean);
    @(negedge clk);
    req = 1'b1; we = wr; addr = {3'(b), 4'(w)}; wdata = d;
    waited = 0; clean = 1'b1;
    #1;
    vfirst = vd;
    while (!gnt && waited < 50) begin
      waited++;
      @(negedge clk); #1;
      if (!gnt && (ls[b] || ds[b] || sd[b] || rdy[b])) clean = 1'b0;
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    #1;
    rd = rdata;
    if (!wr) chk(rvalid == 1'b1, "R1 rvalid after read grant", int'(rvalid), 1);
  endtask

  initial begin
    int wt; logic [7:0] rd; logic vf, cl;
    rst_n = 1'b0; half = 1'b0; boot = 1'b0; req = 1'b0; we = 1'b0;
    lim = '0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(rdy == 8'hFF, "R11 all ready", int'(rdy), 8'hFF);
    chk((ls | ds | sd) == 8'h00, "R11 no sleep control", int'(ls | ds | sd), 0);
    chk(gnt == 1'b0, "R11 no grant", int'(gnt), 0);

    // startup writes (later discarded by shutdown)
    for (int b = 0; b < 8; b++)
      for (int w = 0; w < 16; w++) begin
        access(1'b1, b, w, ~pat(b, w), wt, rd, vf, cl);
        chk(wt == 0, "R1 pre-boot write granted at once", wt, 0);
      end

    boot = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(sd == 8'hFF, "R5 all banks shut down after boot", int'(sd), 8'hFF);
    chk(rdy == 8'h00, "R5 no bank ready", int'(rdy), 0);

    access(1'b0, 2, 3, 8'h00, wt, rd, vf, cl);
    chk(vf == 1'b1, "R8 void on shutdown bank", int'(vf), 1);
    chk(wt == 5, "R7 wake from shutdown", wt, 5);
    chk(cl == 1'b1, "R7 quiet wake window", int'(cl), 1);
    chk(rd == 8'hFF, "R5 startup data lost", int'(rd), 8'hFF);

    // fill banks 0..5 after boot
    for (int b = 0; b < 6; b++)
      for (int w = 0; w < 16; w++) begin
        access(1'b1, b, w, pat(b, w), wt, rd, vf, cl);
        chk(wt == ((b != 2 && w == 0) ? 5 : 0), "R7 write wake latency", wt,
            (b != 2 && w == 0) ? 5 : 0);
      end
    access(1'b0, 6, 0, 8'h00, wt, rd, vf, cl);
    chk(wt == 5, "R7 bank 6 wake", wt, 5);
    chk(rd == 8'hFF, "R4 unwritten word", int'(rd), 8'hFF);

    for (int b = 0; b < 6; b++)
      for (int w = 0; w < 16; w++) begin
        access(1'b0, b, w, 8'h00, wt, rd, vf, cl);
        chk(rd == pat(b, w), "R1 read back", int'(rd), int'(pat(b, w)));
      end

    // half bandwidth
    @(negedge clk); half = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(rdy == 8'h0F, "R3 low banks stay ready", int'(rdy), 8'h0F);
    chk(ls == 8'h30, "R3 written upper banks retain", int'(ls), 8'h30);
    chk(ds == 8'h40, "R4 used empty bank deep sleep", int'(ds), 8'h40);
    chk(sd == 8'h80, "R4 unused bank shutdown", int'(sd), 8'h80);

    @(negedge clk); req = 1'b1; we = 1'b0; addr = {3'd5, 4'd0};
    #1;
    chk(blk == 1'b1, "R2 refused in half mode", int'(blk), 1);
    chk(gnt == 1'b0, "R2 no grant in half mode", int'(gnt), 0);
    chk(vd == 1'b0, "R8 no void on retaining bank", int'(vd), 0);
    repeat (3) @(negedge clk);
    #1;
    chk(gnt == 1'b0 && blk == 1'b1, "R2 still refused", int'(gnt), 0);
    chk(ls[5] == 1'b1, "R2 refused bank unchanged", int'(ls[5]), 1);
    @(negedge clk); req = 1'b0;

    access(1'b0, 1, 7, 8'h00, wt, rd, vf, cl);
    chk(wt == 0 && rd == pat(1, 7), "R3 low bank data kept", int'(rd), int'(pat(1, 7)));

    // idle sleep
    @(negedge clk); lim = 6'd4;
    access(1'b0, 0, 0, 8'h00, wt, rd, vf, cl);
    repeat (3) @(negedge clk);
    #1;
    chk(ls[0] == 1'b0, "R6 awake in last quiet cycle", int'(ls[0]), 0);
    @(negedge clk); #1;
    chk(ls[0] == 1'b1, "R6 idle sleep", int'(ls[0]), 1);

    access(1'b0, 0, 5, 8'h00, wt, rd, vf, cl);
    chk(wt == 3, "R7 wake from retaining sleep", wt, 3);
    chk(cl == 1'b1, "R7 quiet light wake", int'(cl), 1);
    chk(vf == 1'b0, "R8 no void on light sleep", int'(vf), 0);
    chk(rd == pat(0, 5), "R3 data kept through light sleep", int'(rd), int'(pat(0, 5)));

    // collision: request in the cycle the idle count expires
    access(1'b0, 2, 0, 8'h00, wt, rd, vf, cl);
    repeat (2) @(negedge clk);
    access(1'b0, 2, 1, 8'h00, wt, rd, vf, cl);
    chk(wt == 0, "R6 request wins over idle expiry", wt, 0);
    chk(ls[2] == 1'b0, "R6 no sleep after colliding request", int'(ls[2]), 0);

    @(negedge clk); lim = 6'd0;
    access(1'b0, 1, 2, 8'h00, wt, rd, vf, cl);
    chk(wt == 3, "R7 bank 1 light wake", wt, 3);
    repeat (20) @(negedge clk);
    #1;
    chk(rdy[1] == 1'b1, "R6 zero limit disables idle sleep", int'(rdy[1]), 1);

    // back to full
    @(negedge clk); half = 1'b0;
    repeat (2) @(negedge clk);
    access(1'b0, 4, 9, 8'h00, wt, rd, vf, cl);
    chk(wt == 3, "R3 upper bank light wake", wt, 3);
    chk(rd == pat(4, 9), "R3 upper bank retained", int'(rd), int'(pat(4, 9)));
    access(1'b0, 6, 1, 8'h00, wt, rd, vf, cl);
    chk(vf == 1'b1 && wt == 5, "R8 void and deep wake bank 6", wt, 5);
    chk(rd == 8'hFF, "R4 deep sleep lost", int'(rd), 8'hFF);
    access(1'b0, 7, 0, 8'h00, wt, rd, vf, cl);
    chk(vf == 1'b1 && wt == 5, "R7 shutdown wake bank 7", wt, 5);
    chk(rd == 8'hFF, "R5 bank 7 startup data lost", int'(rd), 8'hFF);
    access(1'b0, 5, 15, 8'h00, wt, rd, vf, cl);
    chk(wt == 3 && rd == pat(5, 15), "R2 bank 5 usable in full mode", int'(rd),
        int'(pat(5, 15)));

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule